// File: doc/BRIEF.md
# Comma Synchronizer and Byte-Lane Aligner

This block sits after a multi-lane symbol decoder on the receive path of a serial link. Each clock it takes one word of decoded bytes, one byte per lane, with a control-symbol flag and a code-group-good flag for every lane. A synchronization state machine checks the symbols in lane order, lane 0 first. It reports the link as synchronized only after it has seen one comma (control symbol) followed directly by three data symbols.

While the link is out of sync, the block searches for a comma. When a comma opens a run that is still alive at the end of the word, the block stores that comma's lane as a rotation amount. From then on the outgoing word is rebuilt from the previous word and the current word, so that the comma lands in the least significant byte lane. The rotation stays frozen until the state machine falls back to loss of sync and a new run begins.

Top module: `comma_lane_align`

## Requirements
- R1: During and after synchronous reset (active high), `sync_acquired` is 0, `align_en` is 1 and `out_data` is 0.
- R2: In loss of sync, only a valid control symbol (k=1, good=1) opens a candidate run. A data symbol, or any symbol whose good flag is 0 (including one with k=1), leaves the machine in loss of sync.
- R3: In each of the three comma-detect steps, a valid data symbol (k=0, good=1) advances one step. A control symbol or a symbol whose good flag is 0 returns the machine to loss of sync.
- R4: A valid data symbol in the third comma-detect step enters the synchronized state, and `sync_acquired` reads 1 after that clock edge.
- R5: The symbols of a word are applied in order from lane 0 (bits 7:0) upward within one clock. A single word carrying comma, data, data, data in lanes 0 to 3 therefore reaches sync in one cycle.
- R6: In the synchronized state, a symbol with good flag 0 drops the machine to loss of sync. Valid control and data symbols keep it synchronized. The later lanes of the same word are still processed from the new state.
- R7: `align_en` is 1 exactly when the machine ends the last word in loss of sync. It stays 1 across a word that holds no valid control symbol.
- R8: The stored rotation takes the lane index of the comma that opened the run still in progress at the end of the word. Other commas in the word are ignored. With no such opening, the rotation is unchanged.
- R9: `out_data` is registered. With rotation r, lane j of the output is byte r+j of the concatenation {current word, previous word}, whose lanes 0..3 hold the previous word. The rotation used is the value stored before the current word. A comma captured in lane r therefore appears in output lane 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Decoded bytes; lane i in bits 8i+7:8i |
| in_k | input | 4 | Per-lane control-symbol flag |
| in_ok | input | 4 | Per-lane flag: code group valid and no disparity error |
| out_data | output | 32 | Realigned bytes, comma in lane 0 once locked |
| sync_acquired | output | 1 | Link synchronized |
| align_en | output | 1 | Aligner searching for a comma |

## Verification
The hardest situation to reach from the ports is a word that breaks a run and then restarts it in a later lane of the same word. In that word the machine passes through loss of sync and leaves it again within one cycle. `align_en` never shows a 1, yet the rotation must move to the new comma's lane. The stimulus table drives a synchronized link into a word with an invalid lane 1, a comma in lane 2 and data in lane 3. The next word then finishes the run, and the check confirms that byte 2 of the earlier word arrives in output lane 0. Further rows place two commas in one word and mark a comma as invalid, to show that only the comma opening a surviving run counts.

// File: rtl/cla_pkg.sv
package cla_pkg;

    typedef enum logic [2:0] {
        ST_LOS  = 3'd0,
        ST_CD1  = 3'd1,
        ST_CD2  = 3'd2,
        ST_CD3  = 3'd3,
        ST_SYNC = 3'd4
    } sync_st_e;

    // One symbol step of the synchronization machine.
    function automatic sync_st_e sync_step(sync_st_e s, logic k, logic ok);
        logic is_k;
        logic is_d;
        sync_st_e n;
        is_k = k & ok;
        is_d = ~k & ok;
        case (s)
            ST_LOS:  n = is_k ? ST_CD1 : ST_LOS;
            ST_CD1:  n = is_d ? ST_CD2 : ST_LOS;
            ST_CD2:  n = is_d ? ST_CD3 : ST_LOS;
            ST_CD3:  n = is_d ? ST_SYNC : ST_LOS;
            ST_SYNC: n = ok ? ST_SYNC : ST_LOS;
            default: n = ST_LOS;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cla_sync_fsm.sv
module cla_sync_fsm
    import cla_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LW    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   k,
    input  logic [LANES-1:0]   ok,
    output sync_st_e           state_q,
    output logic               start_vld,
    output logic [LW-1:0]      start_lane
);

    sync_st_e chain [LANES+1];
    logic     any_start;

    assign chain[0] = state_q;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_step
            assign chain[i+1] = sync_step(chain[i], k[i], ok[i]);
        end
    endgenerate

    // Last lane where a run was opened; only one run can survive the word.
    always_comb begin
        any_start  = 1'b0;
        start_lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (chain[i] == ST_LOS && chain[i+1] == ST_CD1) begin
                any_start  = 1'b1;
                start_lane = LW'(i);
            end
        end
        start_vld = any_start && (chain[LANES] != ST_LOS);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOS;
        else     state_q <= chain[LANES];
    end

    // R1: reset leaves the machine out of sync
    a_r1_reset_los: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> state_q == ST_LOS);

    // R2: without a valid comma the machine cannot leave loss of sync
    a_r2_los_needs_k: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOS && !(|(k & ok))) |=> state_q == ST_LOS);

    // R6: a bad code group while synchronized breaks sync
    a_r6_bad_drops: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SYNC && !(&ok)) |=> state_q != ST_SYNC);

endmodule

// File: rtl/cla_lane_rotator.sv
module cla_lane_rotator #(
    parameter int LANES = 4,
    parameter int BW    = 8,
    parameter int LW    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [LW-1:0]         load_lane,
    input  logic [LANES*BW-1:0]   in_data,
    output logic [LANES*BW-1:0]   out_data
);

    localparam int DW = LANES * BW;

    logic [DW-1:0]   prev_q;
    logic [LW-1:0]   rot_q;
    logic [2*DW-1:0] joined;
    logic [DW-1:0]   rotated;

    assign joined = {in_data, prev_q};

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            always_comb begin
                rotated[j*BW +: BW] = joined[(int'(rot_q) + j)*BW +: BW];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            rot_q    <= '0;
            out_data <= '0;
        end else begin
            prev_q   <= in_data;
            out_data <= rotated;
            if (load) rot_q <= load_lane;
        end
    end

    // R8: rotation is frozen unless a new run is opened
    a_r8_rot_frozen: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(rot_q));

    // R1: output word is cleared by reset
    a_r1_out_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> out_data == '0);

endmodule

// File: rtl/comma_lane_align.sv
module comma_lane_align
    import cla_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BW    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES*BW-1:0]   in_data,
    input  logic [LANES-1:0]      in_k,
    input  logic [LANES-1:0]      in_ok,
    output logic [LANES*BW-1:0]   out_data,
    output logic                  sync_acquired,
    output logic                  align_en
);

    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    sync_st_e      state;
    logic          start_vld;
    logic [LW-1:0] start_lane;

    cla_sync_fsm #(.LANES(LANES), .LW(LW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .k          (in_k),
        .ok         (in_ok),
        .state_q    (state),
        .start_vld  (start_vld),
        .start_lane (start_lane)
    );

    cla_lane_rotator #(.LANES(LANES), .BW(BW), .LW(LW)) u_rot (
        .clk       (clk),
        .rst       (rst),
        .load      (start_vld),
        .load_lane (start_lane),
        .in_data   (in_data),
        .out_data  (out_data)
    );

    assign sync_acquired = (state == ST_SYNC);
    assign align_en      = (state == ST_LOS);

    // R7: the search stays enabled across a word with no valid comma
    a_r7_en_held: assert property (@(posedge clk) disable iff (rst)
        (align_en && !(|(in_k & in_ok))) |=> align_en);

endmodule

// File: tb/comma_lane_align_bench.sv
module comma_lane_align_bench;

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  k;
        logic [3:0]  ok;
        logic        s;
        logic        e;
        logic [31:0] o;
    } vec_t;

    localparam int NV = 18;
    // Expected values apply after the edge that samples the row.
    localparam vec_t VECS [NV] = '{
        '{32'h03020100, 4'b0000, 4'b1111, 1'b0, 1'b1, 32'h00000000}, // R2 R9
        '{32'h13121110, 4'b0100, 4'b1111, 1'b0, 1'b0, 32'h03020100}, // R2 R8
        '{32'h23222120, 4'b0000, 4'b1111, 1'b1, 1'b0, 32'h21201312}, // R4 R9
        '{32'h33323130, 4'b0001, 4'b1111, 1'b1, 1'b0, 32'h31302322}, // R6 K kept
        '{32'h43424140, 4'b0000, 4'b1101, 1'b0, 1'b1, 32'h41403332}, // R6 drop
        '{32'h53525150, 4'b1000, 4'b1111, 1'b0, 1'b0, 32'h51504342}, // R8 lane3
        '{32'h63626160, 4'b0000, 4'b1111, 1'b1, 1'b0, 32'h62616053}, // R4 R9
        '{32'h73727170, 4'b0010, 4'b1111, 1'b1, 1'b0, 32'h72717063}, // R8 hold
        '{32'h83828180, 4'b0000, 4'b0000, 1'b0, 1'b1, 32'h82818073}, // R6
        '{32'h93929190, 4'b0011, 4'b1111, 1'b0, 1'b1, 32'h92919083}, // R3 K in cd1
        '{32'hA3A2A1A0, 4'b0001, 4'b1111, 1'b1, 1'b0, 32'hA2A1A093}, // R5 one word
        '{32'hB3B2B1B0, 4'b0000, 4'b1111, 1'b1, 1'b0, 32'hA3A2A1A0}, // R9 rot 0
        '{32'hC3C2C1C0, 4'b0100, 4'b1101, 1'b0, 1'b0, 32'hB3B2B1B0}, // R6 R8 restart
        '{32'hD3D2D1D0, 4'b1000, 4'b1111, 1'b1, 1'b0, 32'hD1D0C3C2}, // R8 R9
        '{32'hE3E2E1E0, 4'b0000, 4'b0000, 1'b0, 1'b1, 32'hE1E0D3D2}, // R6
        '{32'hF3F2F1F0, 4'b1000, 4'b1111, 1'b0, 1'b0, 32'hF1F0E3E2}, // R2
        '{32'h07060504, 4'b0010, 4'b1111, 1'b0, 1'b1, 32'h060504F3}, // R3 K in cd2
        '{32'h17161514, 4'b0001, 4'b1110, 1'b0, 1'b1, 32'h16151407}  // R2 bad K
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] in_data;
    logic [3:0]  in_k;
    logic [3:0]  in_ok;
    logic [31:0] out_data;
    logic        sync_acquired;
    logic        align_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    comma_lane_align u_comma_lane_align (
        .clk           (clk),
        .rst           (rst),
        .in_data       (in_data),
        .in_k          (in_k),
        .in_ok         (in_ok),
        .out_data      (out_data),
        .sync_acquired (sync_acquired),
        .align_en      (align_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] d, input logic [3:0] k, input logic [3:0] ok);
        in_data = d;
        in_k    = k;
        in_ok   = ok;
    endtask

    initial begin
        rst = 1'b1;
        drive(32'h0, 4'h0, 4'hF);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sync", {31'b0, sync_acquired}, 32'd0);
        check("R1 en",   {31'b0, align_en},      32'd1);
        check("R1 out",  out_data,               32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].d, VECS[i].k, VECS[i].ok);
            @(negedge clk);
            check($sformatf("R4/R6 sync row %0d", i), {31'b0, sync_acquired}, {31'b0, VECS[i].s});
            check($sformatf("R7 en row %0d", i),      {31'b0, align_en},      {31'b0, VECS[i].e});
            check($sformatf("R9 out row %0d", i),     out_data,               VECS[i].o);
        end

        // R5: comma and three data symbols in one word reach sync at once
        drive(32'h44332211, 4'b0001, 4'hF);
        @(negedge clk);
        check("R5 sync one word", {31'b0, sync_acquired}, 32'd1);

        // R1: reset in mid-operation clears everything
        rst = 1'b1;
        @(negedge clk);
        check("R1 sync mid", {31'b0, sync_acquired}, 32'd0);
        check("R1 en mid",   {31'b0, align_en},      32'd1);
        check("R1 out mid",  out_data,               32'd0);
        rst = 1'b0;

        // R7: data-only words keep the search on
        drive(32'h55555555, 4'b0000, 4'hF);
        repeat (2) @(negedge clk);
        check("R7 en held", {31'b0, align_en}, 32'd1);
        // R9: rotation back at 0 after reset, output is previous word
        check("R9 rot reset", out_data, 32'h55555555);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule